// File: doc/BRIEF.md
# Shift Operand Decoder and Barrel Shifter

This block produces the shifted second operand of an ALU together with the shifter carry. It takes a 32-bit operand, a carry-in and an instruction word. From the instruction word it pulls a 2-bit shift kind and a 5-bit shift field. Two word layouts are supported: a wide one and a compact one.

In immediate mode the 5-bit field is turned into a shift amount. A zero field is read in a special way: a right shift by zero means a shift by 32, and a rotate by zero means a one-bit rotate through the carry. In register mode the amount comes from a separate 8-bit input, and the four kinds are plain shifts and rotates.

The block is purely combinational. The operand, the carry-in and the instruction word are control-style inputs with no handshake, so no back-pressure applies. The result, the carry-out and a valid flag settle within the same cycle.

Top module: `shop_unit`

## Requirements
- R1: With `compact_layout`=0 the shift kind is taken from instruction bits 6:5 and the 5-bit shift field from bits 11:7.
- R2: With `compact_layout`=1 the shift kind is taken from bits 5:4, and the shift field is formed as {bits 14:12, bits 7:6}, with bit 14 as its MSB.
- R3: In immediate mode (`reg_mode`=0), kind 0 shifts left by the field. Kind 1 (logical right) and kind 2 (arithmetic right) shift by the field, except that a field of 0 means a shift by 32.
- R4: In immediate mode, kind 3 with a field of 0 is a one-bit rotate through carry. The result is {carry_in, op_value[31:1]} and the carry-out is op_value[0]. Kind 3 with a nonzero field rotates right by the field.
- R5: In register mode (`reg_mode`=1), kinds 0, 1, 2 and 3 are left shift, logical right, arithmetic right and rotate right, each by `reg_amount`. There is no rotate through carry in this mode.
- R6: An amount of 0 for any operation other than the rotate through carry gives result = op_value and carry-out = carry_in.
- R7: Left shift by n, for 1..31: the carry-out is op_value[32-n]. By 32: the result is 0 and the carry-out is op_value[0]. Above 32: the result is 0 and the carry-out is 0.
- R8: Logical right shift by n, for 1..32: the carry-out is op_value[n-1] and zeros fill from the top. Above 32: the result is 0 and the carry-out is 0.
- R9: Arithmetic right shift by n, for 1..32: vacated bits copy op_value[31] and the carry-out is op_value[n-1].
- R10: Arithmetic right shift by more than 32 drives `valid` low, the result to 0 and the carry-out to 0.
- R11: Rotate right by a nonzero n rotates by n mod 32, and the carry-out equals bit 31 of the result.
- R12: `valid` is high for every case other than the one in R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_value | input | 32 | Operand to shift |
| carry_in | input | 1 | Incoming carry flag |
| insn_word | input | 32 | Instruction word holding the shift kind and field |
| compact_layout | input | 1 | 0 selects the wide layout, 1 the compact layout |
| reg_mode | input | 1 | 0 decodes the immediate field, 1 uses reg_amount |
| reg_amount | input | 8 | Register-supplied shift amount |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry |
| valid | output | 1 | Low when the requested shift is rejected |

## Verification
There is no stored state, so a wrong decode or a wrong shifter lane shows at `result`, `carry_out` or `valid` in the same evaluation as the input that selects it. A mis-sliced field makes whole families of instruction words produce the wrong amount; the compact layout's split field is the most sensitive spot. Errors at the edges show only at the amounts 0, 32 and 33, in the carry bit or the valid flag. For that reason the amount sweep is aimed exactly at those values.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/shop_field_extract.sv
module shop_field_extract #(
  parameter int INSN_W = 32,
  parameter int FIELD_W = 5
) (
  input  logic [INSN_W-1:0]  insn_word,
  input  logic               compact_layout,
  output logic [1:0]         kind_field,
  output logic [FIELD_W-1:0] amt_field
);
  always_comb begin
    if (compact_layout) begin
      kind_field = insn_word[5:4];
      amt_field  = {insn_word[14:12], insn_word[7:6]};
    end else begin
      kind_field = insn_word[6:5];
      amt_field  = insn_word[11:7];
    end
  end
endmodule

// File: rtl/shop_decode.sv
module shop_decode
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FIELD_W = 5,
  parameter int AMT_W = 8
) (
  input  logic [1:0]         kind_field,
  input  logic [FIELD_W-1:0] amt_field,
  input  logic               reg_mode,
  input  logic [AMT_W-1:0]   reg_amount,
  output shift_kind_e        kind,
  output logic [AMT_W-1:0]   amount
);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);
  localparam logic [AMT_W-1:0] ONE_AMT  = AMT_W'(1);

  logic field_zero;
  assign field_zero = (amt_field == '0);

  always_comb begin
    if (reg_mode) begin
      amount = reg_amount;
      unique case (kind_field)
        2'd0:    kind = SK_LSL;
        2'd1:    kind = SK_LSR;
        2'd2:    kind = SK_ASR;
        default: kind = SK_ROR;
      endcase
    end else begin
      amount = AMT_W'(amt_field);
      unique case (kind_field)
        2'd0: kind = SK_LSL;
        2'd1: begin
          kind = SK_LSR;
          if (field_zero) amount = FULL_AMT;
        end
        2'd2: begin
          kind = SK_ASR;
          if (field_zero) amount = FULL_AMT;
        end
        default: begin
          if (field_zero) begin
            kind   = SK_RRX;
            amount = ONE_AMT;
          end else begin
            kind = SK_ROR;
          end
        end
      endcase
    end
  end

  always_comb begin
    if (!reg_mode && kind == SK_RRX)
      assert_rrx_amount_one_R4: assert (amount == ONE_AMT);
    if (reg_mode)
      assert_reg_no_rrx_R5: assert (kind != SK_RRX);
  end
endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W = 8
) (
  input  logic [DATA_W-1:0] value,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amount,
  input  logic              cin,
  output logic [DATA_W-1:0] result,
  output logic              cout,
  output logic              ok
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

  logic [SH_W-1:0]   sh;
  logic              amt_zero, amt_full, amt_over;
  logic [DATA_W-1:0] lsl_r, lsr_r, asr_r, ror_r;
  logic              lsl_c, lsr_c, asr_c;
  logic [DATA_W:0]   asr_ext;

  assign sh       = amount[SH_W-1:0];
  assign amt_zero = (amount == '0);
  assign amt_full = (amount == FULL_AMT);
  assign amt_over = (amount > FULL_AMT);

  always_comb begin
    {lsl_c, lsl_r} = {1'b0, value} << sh;
    {lsr_r, lsr_c} = {value, 1'b0} >> sh;
    asr_ext        = $signed({value, 1'b0}) >>> sh;
    {asr_r, asr_c} = asr_ext;
    ror_r          = (value >> sh) | (value << (DATA_W - int'(sh)));
  end

  always_comb begin
    ok     = 1'b1;
    result = value;
    cout   = cin;
    if (kind == SK_RRX) begin
      if (amount == AMT_W'(1)) begin
        result = {cin, value[DATA_W-1:1]};
        cout   = value[0];
      end else begin
        ok     = 1'b0;
        result = '0;
        cout   = 1'b0;
      end
    end else if (!amt_zero) begin
      unique case (kind)
        SK_LSL: begin
          if (amt_over)      begin result = '0; cout = 1'b0; end
          else if (amt_full) begin result = '0; cout = value[0]; end
          else               begin result = lsl_r; cout = lsl_c; end
        end
        SK_LSR: begin
          if (amt_over)      begin result = '0; cout = 1'b0; end
          else if (amt_full) begin result = '0; cout = value[DATA_W-1]; end
          else               begin result = lsr_r; cout = lsr_c; end
        end
        SK_ASR: begin
          if (amt_over) begin
            ok = 1'b0; result = '0; cout = 1'b0;
          end else if (amt_full) begin
            result = {DATA_W{value[DATA_W-1]}};
            cout   = value[DATA_W-1];
          end else begin
            result = asr_r; cout = asr_c;
          end
        end
        default: begin
          result = ror_r;
          cout   = ror_r[DATA_W-1];
        end
      endcase
    end
  end

  always_comb begin
    if (!ok)
      assert_reject_zero_R10: assert (result == '0 && !cout);
    if (kind == SK_ROR && !amt_zero)
      assert_ror_carry_msb_R11: assert (cout == result[DATA_W-1]);
    if (kind != SK_RRX && amt_zero)
      assert_zero_amt_pass_R6: assert (ok && result == value && cout == cin);
    if (kind == SK_LSL && amt_over)
      assert_lsl_over_clear_R7: assert (result == '0 && !cout && ok);
  end
endmodule

// File: rtl/shop_unit.sv
module shop_unit
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INSN_W = 32,
  parameter int FIELD_W = 5,
  parameter int AMT_W = 8
) (
  input  logic [DATA_W-1:0] op_value,
  input  logic              carry_in,
  input  logic [INSN_W-1:0] insn_word,
  input  logic              compact_layout,
  input  logic              reg_mode,
  input  logic [AMT_W-1:0]  reg_amount,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              valid
);
  logic [1:0]         kind_field;
  logic [FIELD_W-1:0] amt_field;
  shift_kind_e        kind;
  logic [AMT_W-1:0]   amount;

  shop_field_extract #(.INSN_W(INSN_W), .FIELD_W(FIELD_W)) u_extract (
    .insn_word      (insn_word),
    .compact_layout (compact_layout),
    .kind_field     (kind_field),
    .amt_field      (amt_field)
  );

  shop_decode #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .AMT_W(AMT_W)) u_decode (
    .kind_field (kind_field),
    .amt_field  (amt_field),
    .reg_mode   (reg_mode),
    .reg_amount (reg_amount),
    .kind       (kind),
    .amount     (amount)
  );

  shop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .value  (op_value),
    .kind   (kind),
    .amount (amount),
    .cin    (carry_in),
    .result (result),
    .cout   (carry_out),
    .ok     (valid)
  );

  always_comb begin
    if (!valid)
      assert_reject_only_asr_R12: assert (reg_mode && kind == SK_ASR);
  end
endmodule

// File: tb/test_shop_unit.sv
module test_shop_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] op_value = '0;
  logic        carry_in = 1'b0;
  logic [31:0] insn_word = '0;
  logic        compact_layout = 1'b0;
  logic        reg_mode = 1'b0;
  logic [7:0]  reg_amount = '0;
  logic [31:0] result;
  logic        carry_out;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  shop_unit i_shop_unit (
    .op_value(op_value), .carry_in(carry_in), .insn_word(insn_word),
    .compact_layout(compact_layout), .reg_mode(reg_mode),
    .reg_amount(reg_amount), .result(result), .carry_out(carry_out),
    .valid(valid)
  );

  // kinds for the model: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate-through-carry
  task automatic model(input logic [31:0] v, input int k, input int n, input logic ci,
                       output logic [31:0] r, output logic c, output logic ok);
    r = v; c = ci; ok = 1'b1;
    if (k == 4) begin
      r = {ci, v[31:1]}; c = v[0];
    end else if (k == 2 && n > 32) begin
      r = '0; c = 1'b0; ok = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        case (k)
          0: begin c = r[31]; r = r << 1; end
          1: begin c = r[0];  r = r >> 1; end
          2: begin c = r[0];  r = {r[31], r[31:1]}; end
          default: begin r = {r[0], r[31:1]}; c = r[31]; end
        endcase
      end
    end
  endtask

  function automatic logic [31:0] mk_insn(input bit cmp, input logic [1:0] t,
                                          input logic [4:0] f, input logic [31:0] noise);
    logic [31:0] w;
    if (cmp) begin
      w = noise & ~32'h0000_70F0;
      w[5:4] = t; w[14:12] = f[4:2]; w[7:6] = f[1:0];
    end else begin
      w = noise & ~32'h0000_0FE0;
      w[6:5] = t; w[11:7] = f;
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic ec, input logic eok);
    #2;
    checks++;
    if (result !== er || carry_out !== ec || valid !== eok) begin
      errors++;
      $display("FAIL %s: got result=%h carry=%b valid=%b expected result=%h carry=%b valid=%b",
               req, result, carry_out, valid, er, ec, eok);
    end
    @(negedge clk);
  endtask

  task automatic apply(input string req, input logic [31:0] v, input logic ci, input bit cmp,
                       input bit rm, input logic [1:0] t, input logic [4:0] f,
                       input logic [7:0] ra, input int k, input int n);
    logic [31:0] er; logic ec; logic eok;
    op_value = v; carry_in = ci; compact_layout = cmp; reg_mode = rm;
    reg_amount = ra; insn_word = mk_insn(cmp, t, f, $urandom());
    model(v, k, n, ci, er, ec, eok);
    check(req, er, ec, eok);
  endtask

  task automatic t_idle;
    check("R6 idle", 32'h0, 1'b0, 1'b1);
  endtask

  task automatic t_wide_fields;
    apply("R1 wide lsl 7", 32'h8123_4567, 0, 0, 0, 2'd0, 5'd7, 8'd0, 0, 7);
    apply("R1 wide lsr 19", 32'hF0F0_1234, 1, 0, 0, 2'd1, 5'd19, 8'd0, 1, 19);
    apply("R1 wide ror 13", 32'h1357_9BDF, 0, 0, 0, 2'd3, 5'd13, 8'd0, 3, 13);
  endtask

  task automatic t_compact_fields;
    apply("R2 compact lsl 22", 32'h0000_FFFF, 0, 1, 0, 2'd0, 5'd22, 8'd0, 0, 22);
    apply("R2 compact asr 3", 32'h8000_00F0, 0, 1, 0, 2'd2, 5'd3, 8'd0, 2, 3);
    apply("R2 compact ror 29", 32'hDEAD_BEEF, 1, 1, 0, 2'd3, 5'd29, 8'd0, 3, 29);
    apply("R2 compact lsr 1", 32'h0000_0003, 0, 1, 0, 2'd1, 5'd1, 8'd0, 1, 1);
  endtask

  task automatic t_imm_zero;
    apply("R3 lsr imm0 is 32", 32'h8000_0001, 0, 0, 0, 2'd1, 5'd0, 8'd0, 1, 32);
    apply("R3 asr imm0 is 32", 32'h8000_0000, 0, 1, 0, 2'd2, 5'd0, 8'd0, 2, 32);
    apply("R3 asr imm0 pos", 32'h7FFF_FFFF, 1, 0, 0, 2'd2, 5'd0, 8'd0, 2, 32);
    apply("R6 lsl imm0 pass", 32'hCAFE_F00D, 1, 0, 0, 2'd0, 5'd0, 8'd0, 0, 0);
  endtask

  task automatic t_rrx;
    apply("R4 rrx cin1", 32'h0000_0003, 1, 0, 0, 2'd3, 5'd0, 8'd0, 4, 1);
    apply("R4 rrx cin0", 32'h8000_0000, 0, 1, 0, 2'd3, 5'd0, 8'd0, 4, 1);
  endtask

  task automatic t_reg_sweep;
    int amts[6] = '{0, 1, 31, 32, 33, 255};
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 6; a++) begin
        for (int r = 0; r < 3; r++) begin
          string tag;
          case (k)
            0: tag = "R7 reg lsl";
            1: tag = "R8 reg lsr";
            2: tag = (amts[a] > 32) ? "R10 reg asr" : "R9 reg asr";
            default: tag = "R11 reg ror";
          endcase
          if (amts[a] == 0) tag = "R6 reg zero";
          apply(tag, (r == 0) ? 32'h8000_0001 : $urandom(), 1'($urandom()), bit'(r & 1), 1,
                2'(k), 5'($urandom()), 8'(amts[a]), k, amts[a]);
        end
      end
    end
  endtask

  task automatic t_reg_no_rrx;
    apply("R5 reg type3 amt1 rotates", 32'h0000_0001, 0, 0, 1, 2'd3, 5'd0, 8'd1, 3, 1);
    apply("R5 reg type3 amt0", 32'h1234_5678, 1, 0, 1, 2'd3, 5'd0, 8'd0, 3, 0);
  endtask

  task automatic t_valid;
    apply("R12 ror 200", 32'hA5A5_0F0F, 0, 0, 1, 2'd3, 5'd0, 8'd200, 3, 200);
    apply("R12 lsr 100", 32'hFFFF_FFFF, 1, 0, 1, 2'd1, 5'd0, 8'd100, 1, 100);
    apply("R10 asr 34", 32'hFFFF_FFFF, 1, 0, 1, 2'd2, 5'd0, 8'd34, 2, 34);
  endtask

  initial begin
    @(negedge clk);
    t_idle();
    t_wide_fields();
    t_compact_fields();
    t_imm_zero();
    t_rrx();
    t_reg_no_rrx();
    t_reg_sweep();
    t_valid();
    for (int i = 0; i < 40; i++) begin
      int k = int'($urandom_range(0, 3));
      int f = int'($urandom_range(1, 31));
      apply("R3 imm random", $urandom(), 1'($urandom()), bit'(i & 1), 0,
            2'(k), 5'(f), 8'd0, k, f);
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule